// File: doc/BRIEF.md
# Pending Interrupt Number Resolver

This block turns the already-masked pending state of an interrupt controller into one global interrupt number. This lets the processor learn which source to service from a single read. The block takes three inputs. The first is a 21-bit summary word. Its low eight bits are directly attached sources, bits 8 and 9 flag activity in the two 32-bit banks, and bits 10 to 20 mirror eleven frequently used bank lines. The other two inputs are the masked pending words of bank 1 and bank 2. Global numbering gives the direct sources 0 to 7, bank 1 bit k the number 8+k, and bank 2 bit k the number 40+k. That makes 72 numbers in all.

The search follows a fixed order. Direct sources come first. The mirrored lines are next: five bank 1 lines, then six bank 2 lines. A full scan of bank 1 follows, then a full scan of bank 2. Each scan runs only when that bank's summary flag is set, and it ignores the bank's mirrored positions. The result is registered once, so the result for a given input appears one clock after that input. Acknowledging sources and holding enable masks are handled elsewhere.

Top module: `pend_num_resolver`

## Requirements
- R1: When the summary word is all zero, valid is low on the next clock, whatever the bank words hold.
- R2: If any summary bit 7..0 is set, the result is the index of the lowest set bit among those eight.
- R3: If summary bits 7..0 are zero, the bank 1 mirror bits are tried in priority order. Bit 10 maps to number 15, bit 11 to 17, bit 12 to 18, bit 13 to 26 and bit 14 to 27. The first one set wins.
- R4: With no direct or bank 1 mirror bit set, the bank 2 mirror bits are tried in priority order. Bit 15 maps to 61, bit 16 to 62, bit 17 to 63, bit 18 to 64, bit 19 to 65 and bit 20 to 70. Every mirror bit takes precedence over both bank scans.
- R5: If none of the above applies and summary bit 8 is set, the result is 8 plus the lowest set bit of bank 1. Bank 1 positions 7, 9, 10, 18 and 19 are excluded from this scan. Bank 1 is not looked at while bit 8 is clear.
- R6: If bank 1 gives nothing and summary bit 9 is set, the result is 40 plus the lowest set bit of bank 2. Bank 2 positions 21 to 25 and 30 are excluded from this scan. Bank 2 is not looked at while bit 9 is clear.
- R7: If a summary flag is set but its bank word is zero after the exclusions, the search moves on to the next step. If no step yields a source, valid is low.
- R8: Outputs change only on a rising clock edge and reflect the inputs sampled at that edge. A synchronous reset drives valid low and the number to zero.
- R9: The number output is zero whenever valid is low, and never exceeds 71 when valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| basic_pend_i | input | 21 | Masked summary word: direct sources, bank flags, mirrored lines |
| bank1_pend_i | input | 32 | Masked bank 1 pending word |
| bank2_pend_i | input | 32 | Masked bank 2 pending word |
| irq_valid_o | output | 1 | A source was found |
| irq_num_o | output | 7 | Global interrupt number, zero when not valid |

## Verification
The bench drives a range of stimuli. It sets direct bits together with lower-ranked bits, which shows whether the direct sources take priority. It sets pairs of mirror bits in reverse order, which exposes a wrong mirror-to-number table or a wrong priority order. It sets bank words that contain only excluded positions, or that have their summary flag clear, which separates a correct bank scan from one that ignores the exclusions or the flags. The lowest and highest bank positions are driven as well. Reset is asserted while inputs are pending. A stream of sparse random vectors is then compared against an independent priority model.

// File: rtl/pend_num_pkg.sv
package pend_num_pkg;

    localparam int BASIC_W  = 21;
    localparam int BANK_W   = 32;
    localparam int NUM_W    = 7;
    localparam int DIRECT_N = 8;
    localparam int SC_LO    = 10;
    localparam int SC_N     = BASIC_W - SC_LO;
    localparam int B1_FLAG  = 8;
    localparam int B2_FLAG  = 9;
    localparam int B1_BASE  = DIRECT_N;
    localparam int B2_BASE  = DIRECT_N + BANK_W;

    // Bank positions mirrored in the summary word; removed from bank scans.
    localparam logic [BANK_W-1:0] B1_EXCL = 32'h000C_0680;
    localparam logic [BANK_W-1:0] B2_EXCL = 32'h43E0_0000;

    typedef struct packed {
        logic             valid;
        logic [NUM_W-1:0] num;
    } res_t;

    // Mirror slot (priority order) to global number.
    function automatic logic [NUM_W-1:0] mirror_num(input logic [3:0] slot);
        case (slot)
            4'd0:    mirror_num = NUM_W'(B1_BASE + 7);
            4'd1:    mirror_num = NUM_W'(B1_BASE + 9);
            4'd2:    mirror_num = NUM_W'(B1_BASE + 10);
            4'd3:    mirror_num = NUM_W'(B1_BASE + 18);
            4'd4:    mirror_num = NUM_W'(B1_BASE + 19);
            4'd5:    mirror_num = NUM_W'(B2_BASE + 21);
            4'd6:    mirror_num = NUM_W'(B2_BASE + 22);
            4'd7:    mirror_num = NUM_W'(B2_BASE + 23);
            4'd8:    mirror_num = NUM_W'(B2_BASE + 24);
            4'd9:    mirror_num = NUM_W'(B2_BASE + 25);
            default: mirror_num = NUM_W'(B2_BASE + 30);
        endcase
    endfunction

endpackage

// File: rtl/pend_lsb_find.sv
module pend_lsb_find #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/pend_num_resolver.sv
module pend_num_resolver
    import pend_num_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [BASIC_W-1:0] basic_pend_i,
    input  logic [BANK_W-1:0]  bank1_pend_i,
    input  logic [BANK_W-1:0]  bank2_pend_i,
    output logic               irq_valid_o,
    output logic [NUM_W-1:0]   irq_num_o
);
    localparam int DIW = $clog2(DIRECT_N);
    localparam int SIW = $clog2(SC_N);
    localparam int BIW = $clog2(BANK_W);

    res_t res_d, res_q;

    logic           dir_hit;
    logic [DIW-1:0] dir_idx;
    logic           sc_hit;
    logic [SIW-1:0] sc_idx;

    pend_lsb_find #(.W(DIRECT_N)) u_dir (
        .vec_i  (basic_pend_i[DIRECT_N-1:0]),
        .found_o(dir_hit),
        .idx_o  (dir_idx)
    );

    pend_lsb_find #(.W(SC_N)) u_sc (
        .vec_i  (basic_pend_i[BASIC_W-1:SC_LO]),
        .found_o(sc_hit),
        .idx_o  (sc_idx)
    );

    logic [1:0]     bank_hit;
    logic [BIW-1:0] bank_idx [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic [BANK_W-1:0] EXCL = (b == 0) ? B1_EXCL : B2_EXCL;
        localparam int                FLAG = (b == 0) ? B1_FLAG : B2_FLAG;
        logic [BANK_W-1:0] scan_vec;
        logic              any;
        assign scan_vec = ((b == 0) ? bank1_pend_i : bank2_pend_i) & ~EXCL;
        pend_lsb_find #(.W(BANK_W)) u_scan (
            .vec_i  (scan_vec),
            .found_o(any),
            .idx_o  (bank_idx[b])
        );
        assign bank_hit[b] = any & basic_pend_i[FLAG];
    end

    always_comb begin
        res_d = '0;
        if (dir_hit) begin
            res_d.valid = 1'b1;
            res_d.num   = NUM_W'(dir_idx);
        end else if (sc_hit) begin
            res_d.valid = 1'b1;
            res_d.num   = mirror_num(4'(sc_idx));
        end else if (bank_hit[0]) begin
            res_d.valid = 1'b1;
            res_d.num   = NUM_W'(B1_BASE) + NUM_W'(bank_idx[0]);
        end else if (bank_hit[1]) begin
            res_d.valid = 1'b1;
            res_d.num   = NUM_W'(B2_BASE) + NUM_W'(bank_idx[1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign irq_valid_o = res_q.valid;
    assign irq_num_o   = res_q.num;

    // R1
    a_r1_empty_invalid: assert property (@(posedge clk) disable iff (rst)
        (basic_pend_i == '0) |=> !irq_valid_o);
    // R2
    a_r2_direct_first: assert property (@(posedge clk) disable iff (rst)
        (|basic_pend_i[DIRECT_N-1:0]) |=> (irq_valid_o && irq_num_o < NUM_W'(DIRECT_N)));
    // R4
    a_r4_mirror_before_scan: assert property (@(posedge clk) disable iff (rst)
        (basic_pend_i[DIRECT_N-1:0] == '0 && |basic_pend_i[BASIC_W-1:SC_LO])
        |=> (irq_valid_o && irq_num_o inside {7'd15, 7'd17, 7'd18, 7'd26, 7'd27,
             7'd61, 7'd62, 7'd63, 7'd64, 7'd65, 7'd70}));
    // R5
    a_r5_scan_skips_mirrors: assert property (@(posedge clk) disable iff (rst)
        (basic_pend_i[DIRECT_N-1:0] == '0 && basic_pend_i[BASIC_W-1:SC_LO] == '0)
        |=> !(irq_valid_o && irq_num_o inside {7'd15, 7'd17, 7'd18, 7'd26, 7'd27,
              7'd61, 7'd62, 7'd63, 7'd64, 7'd65, 7'd70}));
    // R8
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq_valid_o && irq_num_o == '0));
    // R9
    a_r9_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        !irq_valid_o |-> irq_num_o == '0);
    a_r9_in_range: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> irq_num_o <= NUM_W'(B2_BASE + BANK_W - 1));

endmodule

// File: tb/pend_num_resolver_tb_top.sv
module pend_num_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] basic = '0;
    logic [31:0] b1 = '0;
    logic [31:0] b2 = '0;
    logic        valid;
    logic [6:0]  num;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    pend_num_resolver dut_i (
        .clk(clk), .rst(rst),
        .basic_pend_i(basic), .bank1_pend_i(b1), .bank2_pend_i(b2),
        .irq_valid_o(valid), .irq_num_o(num)
    );

    // Independent priority model: -1 means no source.
    function automatic int model(input logic [20:0] s, input logic [31:0] w1,
                                 input logic [31:0] w2);
        int mirror[11] = '{15, 17, 18, 26, 27, 61, 62, 63, 64, 65, 70};
        for (int i = 0; i < 8; i++) if (s[i]) return i;
        for (int k = 0; k < 11; k++) if (s[10 + k]) return mirror[k];
        if (s[8])
            for (int j = 0; j < 32; j++)
                if (w1[j] && !(j inside {7, 9, 10, 18, 19})) return 8 + j;
        if (s[9])
            for (int j = 0; j < 32; j++)
                if (w2[j] && !(j inside {21, 22, 23, 24, 25, 30})) return 40 + j;
        return -1;
    endfunction

    task automatic check(input string tag, input int exp);
        int act;
        act = valid ? int'(num) : -1;
        checks++;
        if (act != exp || (!valid && num != 0)) begin
            fails++;
            $display("FAIL %s: actual valid=%0b num=%0d expected %0d", tag, valid, num, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [20:0] s,
                         input logic [31:0] w1, input logic [31:0] w2);
        @(negedge clk);
        basic = s; b1 = w1; b2 = w2;
        exp_q.push_back(model(s, w1, w2));
        tag_q.push_back(tag);
    endtask

    // Monitor: compares one result per cycle, 2 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset state", -1);
        @(negedge clk);
        rst = 1'b0;

        drive("R1 empty summary", 21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive("R2 lowest direct", 21'h000028, 32'h0, 32'h0);
        drive("R2 direct over mirrors", 21'h1FFC81, 32'h1, 32'h1);
        drive("R2 direct bit7", 21'h000080, 32'h0, 32'h0);
        drive("R3 mirror order 11 before 12", 21'h001800, 32'h0, 32'h0);
        drive("R3 mirror bit14", 21'h004000, 32'h0, 32'h0);
        drive("R3 bank1 mirror before bank2", 21'h108800, 32'h0, 32'h0);
        drive("R4 bank2 mirror 17 before 20", 21'h120000, 32'h0, 32'h0);
        drive("R4 mirror beats bank scan", 21'h100300, 32'h1, 32'h1);
        drive("R5 bank1 skips excluded", 21'h000100, 32'h0000_1680, 32'h0);
        drive("R5 bank1 bit0", 21'h000100, 32'h0000_0001, 32'h0);
        drive("R5 bank1 bit31", 21'h000100, 32'h8000_0000, 32'h0);
        drive("R5 bank1 ignored without flag", 21'h000200, 32'h0000_0001, 32'h0000_0001);
        drive("R6 bank2 bit31", 21'h000200, 32'h0, 32'h8000_0000);
        drive("R6 bank2 skips excluded", 21'h000200, 32'h0, 32'h43E0_0010);
        drive("R6 bank2 ignored without flag", 21'h000100, 32'h0, 32'h0000_0004);
        drive("R7 bank1 only excluded", 21'h000100, 32'h000C_0680, 32'h0);
        drive("R7 move on to bank2", 21'h000300, 32'h000C_0680, 32'h0000_0008);
        drive("R7 both empty after exclusion", 21'h000300, 32'h000C_0680, 32'h43E0_0000);
        for (int n = 0; n < 300; n++) begin
            logic [20:0] s;
            s = 21'($urandom);
            if (n % 3 != 0) s = s & 21'($urandom) & 21'($urandom);
            if (n % 4 == 1) s = s & 21'h000300;
            drive("R9 random mix", s, $urandom & $urandom, $urandom & $urandom);
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        rst = 1'b1; basic = 21'h00001; b1 = '1; b2 = '1;
        @(posedge clk);
        #2;
        check("R8 reset while pending", -1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R8 one-cycle latency after reset", 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule